// File: doc/BRIEF.md
# Periodic Sync Timestamp Generator

This block keeps a timestamp word and advances it by a programmable step once every programmable number of clock cycles. Each time the word moves, a single-cycle valid strobe, aligned to the rising clock edge, marks the new value. Downstream logic can capture the timestamp on any cycle where the strobe is high.

The interval is given in clock cycles. A free-running down-counter inside the block measures it, so no external tick is needed. The step is normally set to a frequency constant multiplied by a rate constant. The start value is taken only while reset is held.

Top module: `sync_stamp_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `stamp` takes the value on `startVal` and `stampValid` is low after that edge.
- R2: The first update happens at the P-th rising edge after the last edge where `rst` was high. P is the effective interval.
- R3: Later updates follow every P rising edges. The interval for each period is the effective value of `periodLen` at the edge that began that period, which is the reset edge or the previous update edge.
- R4: At an update edge, `stamp` becomes its previous value plus the `incr` present at that edge. `stampValid` is high for the cycle that follows that edge, so the new value and the strobe appear together.
- R5: `stampValid` is high for exactly one cycle per update and is never high on two cycles in a row.
- R6: Between updates, `stamp` holds its value.
- R7: The addition wraps modulo 2^STAMP_W. No overflow indication is given.
- R8: A `periodLen` value of 0 or 1 is treated as an effective interval of 2. Any other value is used as it is.
- R9: A change of `periodLen` during a period does not shorten or lengthen that period. It takes effect only from the next period.
- R10: A change on `startVal` while `rst` is low has no effect on `stamp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| periodLen | input | CNT_W | Interval between updates, in clock cycles |
| startVal | input | STAMP_W | Timestamp value loaded during reset |
| incr | input | STAMP_W | Step added at each update |
| stamp | output | STAMP_W | Current timestamp |
| stampValid | output | 1 | One-cycle strobe marking a new timestamp |

## Verification
Both outputs are registered, so a decision made at a rising edge is visible right after that edge. The first strobe and its new timestamp show up after exactly P edges from the last reset edge, and every later strobe follows P edges after the one before it. The bench drives inputs on the falling edge and steps a cycle model with those inputs for the coming rising edge. It compares both outputs on the next falling edge, so every expected value is checked in the exact cycle where it becomes due. Directed phases cover reset, wrap, short intervals, a mid-period interval change and start-value changes while running. A long run with random inputs follows.

// File: rtl/ts_pkg.sv
package ts_pkg;

  // Smallest interval the block supports; shorter requests are raised to it.
  localparam int MIN_PERIOD = 2;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;     // take the start value
    logic advance;  // add the step and raise the strobe
  } tsCtl_t;

endpackage

// File: rtl/ts_ctrl.sv
module ts_ctrl
  import ts_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] periodLen,
  output tsCtl_t           ctl
);

  localparam logic [CNT_W-1:0] MIN_LEN    = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] MIN_RELOAD = CNT_W'(MIN_PERIOD - 1);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] reloadVal;
  logic             atZero;

  // Reload value is the interval minus one, with short requests clamped.
  always_comb begin
    if (periodLen < MIN_LEN) reloadVal = MIN_RELOAD;
    else                     reloadVal = periodLen - CNT_W'(1);
  end

  assign atZero = (remain == '0);

  // Down-counter: reset and each update edge load the reload value.
  always_ff @(posedge clk) begin
    if (rst)         remain <= reloadVal;
    else if (atZero) remain <= reloadVal;
    else             remain <= remain - CNT_W'(1);
  end

  always_comb begin
    ctl.load    = rst;
    ctl.advance = !rst && atZero;
  end

endmodule

// File: rtl/ts_datapath.sv
module ts_datapath
  import ts_pkg::*;
#(
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  tsCtl_t             ctl,
  input  logic [STAMP_W-1:0] startVal,
  input  logic [STAMP_W-1:0] incr,
  output logic [STAMP_W-1:0] stamp,
  output logic               stampValid
);

  logic [STAMP_W-1:0] stampNext;

  // Modulo addition: the carry out is dropped.
  assign stampNext = stamp + incr;

  always_ff @(posedge clk) begin
    if (ctl.load) begin
      stamp      <= startVal;
      stampValid <= 1'b0;
    end else begin
      if (ctl.advance) stamp <= stampNext;
      stampValid <= ctl.advance;
    end
  end

endmodule

// File: rtl/sync_stamp_gen.sv
module sync_stamp_gen
  import ts_pkg::*;
#(
  parameter int STAMP_W = 32,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   periodLen,
  input  logic [STAMP_W-1:0] startVal,
  input  logic [STAMP_W-1:0] incr,
  output logic [STAMP_W-1:0] stamp,
  output logic               stampValid
);

  tsCtl_t ctl;

  ts_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .periodLen (periodLen),
    .ctl       (ctl)
  );

  ts_datapath #(.STAMP_W(STAMP_W)) uData (
    .clk        (clk),
    .ctl        (ctl),
    .startVal   (startVal),
    .incr       (incr),
    .stamp      (stamp),
    .stampValid (stampValid)
  );

endmodule

// File: rtl/sync_stamp_gen_chk.sv
module sync_stamp_gen_chk #(
  parameter int STAMP_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [STAMP_W-1:0] startVal,
  input logic [STAMP_W-1:0] incr,
  input logic [STAMP_W-1:0] stamp,
  input logic               stampValid
);

  // R1
  reset_load_chk: assert property (@(posedge clk)
    $past(rst) |-> (stamp == $past(startVal)) && !stampValid);

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    stampValid |=> !stampValid);

  // R6
  stamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(stamp) |-> (stampValid || $past(rst)));

  // R4
  stamp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (stampValid && !$past(rst)) |-> (stamp == STAMP_W'($past(stamp) + $past(incr))));

endmodule

bind sync_stamp_gen sync_stamp_gen_chk #(.STAMP_W(STAMP_W)) uChk (
  .clk        (clk),
  .rst        (rst),
  .startVal   (startVal),
  .incr       (incr),
  .stamp      (stamp),
  .stampValid (stampValid)
);

// File: tb/tb_sync_stamp_gen.sv
module tb_sync_stamp_gen;

  localparam int STAMP_W = 32;
  localparam int CNT_W   = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [CNT_W-1:0]   periodLen = '0;
  logic [STAMP_W-1:0] startVal = '0;
  logic [STAMP_W-1:0] incr = '0;
  logic [STAMP_W-1:0] stamp;
  logic               stampValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic [STAMP_W-1:0] expStamp;
  bit                 expValid;
  int                 left;
  string              curTag;

  always #10 clk = ~clk;

  sync_stamp_gen #(.STAMP_W(STAMP_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .periodLen(periodLen), .startVal(startVal),
    .incr(incr), .stamp(stamp), .stampValid(stampValid)
  );

  function automatic int effPeriod(input int p);
    return (p < 2) ? 2 : p;
  endfunction

  // One cycle: drive at the falling edge, advance the model, compare at next falling edge.
  task automatic step(input bit r, input int p, input logic [STAMP_W-1:0] s,
                      input logic [STAMP_W-1:0] inc);
    rst = r; periodLen = CNT_W'(p); startVal = s; incr = inc;
    if (r) begin
      expStamp = s; expValid = 0; left = effPeriod(p);
    end else begin
      left = left - 1;
      if (left == 0) begin
        expStamp = expStamp + inc; expValid = 1; left = effPeriod(p);
      end else expValid = 0;
    end
    @(posedge clk);
    @(negedge clk);
    testsRun++;
    if (stamp !== expStamp || stampValid !== expValid) begin
      testsFailed++;
      $display("FAIL %s: stamp=%h valid=%b expected stamp=%h valid=%b",
               curTag, stamp, stampValid, expStamp, expValid);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int per;
    logic [STAMP_W-1:0] inc;
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R1: reset loads the start value, strobe low
    curTag = "R1";
    repeat (3) step(1, 5, 32'h0000_1234, 32'd7);

    // R2 / R3 / R4 / R5 / R6: first update after 5 edges, then every 5
    curTag = "R2";
    repeat (5) step(0, 5, 32'h0000_1234, 32'd7);
    curTag = "R3_R4_R5_R6";
    repeat (16) step(0, 5, 32'h0000_1234, 32'd7);

    // R7: wrap modulo width
    curTag = "R7";
    step(1, 3, 32'hFFFF_FFF0, 32'h20);
    repeat (10) step(0, 3, 32'hFFFF_FFF0, 32'h20);

    // R8: interval 0 and 1 behave as 2
    curTag = "R8";
    step(1, 0, 32'h100, 32'd1);
    repeat (8) step(0, 0, 32'h100, 32'd1);
    step(1, 1, 32'h200, 32'd3);
    repeat (8) step(0, 1, 32'h200, 32'd3);

    // R9: interval change mid-period affects only the next period
    curTag = "R9";
    step(1, 4, 32'h0, 32'd10);
    repeat (2) step(0, 4, 32'h0, 32'd10);
    repeat (20) step(0, 7, 32'h0, 32'd10);
    repeat (3) step(0, 3, 32'h0, 32'd10);
    repeat (10) step(0, 6, 32'h0, 32'd10);

    // R10: start value ignored outside reset, step changes picked up at the update edge
    curTag = "R10";
    step(1, 3, 32'h5000, 32'd2);
    for (int k = 0; k < 20; k++)
      step(0, 3, 32'h5000 + 32'(k * 37), 32'(2 + k));

    // Random run
    curTag = "R3_R4_random";
    per = 4; inc = 32'd100;
    step(1, per, $urandom, inc);
    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 16) == 0) per = int'($urandom % 10);
      if (($urandom % 8) == 0)  inc = $urandom;
      step(($urandom % 200) == 0, per, $urandom, inc);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule